// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM with a 19-bit word address and a 16-bit data path split into two 8-bit lanes. Each accepted request is a single read or write. A 2-bit lane mask picks which bytes take part. The block returns read data with a one-cycle strobe. On the memory side it drives a dual-polarity chip select pair, a write strobe, a read (output) strobe, two active-low lane enables, the address, and a split data bus (`ram_dq_o`, `ram_dq_i`, `ram_dq_oe`) that the pad ring turns into a tri-state bus.

Every interval of the memory access is set in nanoseconds by a parameter, together with the clock period. Each interval becomes a whole number of cycles: the value is divided by the period and rounded up, and the result is never less than one cycle. Each access runs through four phases: idle, setup, active and recover. Only one access is in flight at a time.

The request side is valid/ready. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so the requester must hold its request stable until that edge. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and the consumer must take `rsp_rdata` in that cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, the block holds these pin states: `req_ready` = 1, `ram_sel_n` = 1, `ram_sel` = 0, `ram_wr_n` = 1, `ram_rd_n` = 1, `ram_dq_oe` = 0, `rsp_valid` = 0.
- R2: The chip is selected only while an access is in progress. Selected means `ram_sel_n` = 0 and `ram_sel` = 1. Selection lasts through setup, active and recover. During that whole time `ram_addr` holds the address of the accepted request.
- R3: A write with mask 2'b11 stores all 16 bits. A later full-mask read of the same address returns those 16 bits.
- R4: Mask bit 0 controls the low lane: it drives `ram_lo_n` low and moves data bits [7:0]. Mask bit 1 controls the high lane: it drives `ram_hi_n` low and moves data bits [15:8]. A write leaves the lane whose mask bit is 0 unchanged in memory.
- R5: In `rsp_rdata`, every lane whose mask bit is 0 reads as zero.
- R6: A request with mask 2'b00 asserts neither lane enable. As a write it leaves memory unchanged. As a read it returns 16'h0000.
- R7: With default parameters, `ram_wr_n` stays low for 9 cycles and a write keeps `req_ready` low for 11 cycles. In general, the write pulse lasts at least the pulse-width count and at least the turnaround count plus the data-setup count.
- R8: During a write, `ram_dq_oe` rises only after `ram_wr_n` has been low for 4 cycles (the bus-release count). It stays high for 5 cycles while `ram_wr_n` is low. It stays high for 1 hold cycle after `ram_wr_n` rises, and it is low again before `req_ready` returns.
- R9: `ram_rd_n` is high whenever `ram_dq_oe` is high or `ram_wr_n` is low, so the block's driver and the memory's outputs never drive the bus together.
- R10: With default parameters, `ram_rd_n` stays low for 11 cycles during a read. `rsp_valid` pulses for one cycle, in the 12th cycle after the accepting edge. `req_ready` returns after 16 cycles, which leaves 4 cycles for the memory to release the bus.
- R11: A request transfers only on an edge where `req_valid` and `req_ready` are both high. With `req_valid` low, the memory pins stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ram_addr | output | 19 | Memory address |
| ram_sel_n | output | 1 | Active-low chip select |
| ram_sel | output | 1 | Active-high chip select |
| ram_wr_n | output | 1 | Active-low write strobe |
| ram_rd_n | output | 1 | Active-low output enable |
| ram_hi_n | output | 1 | Active-low high-lane enable |
| ram_lo_n | output | 1 | Active-low low-lane enable |
| ram_dq_i | input | 16 | Data from the memory bus |
| ram_dq_o | output | 16 | Data to the memory bus |
| ram_dq_oe | output | 1 | Drive enable for `ram_dq_o` |

## Verification
All results are timed from the edge that accepts the request. Read data is due in the 12th cycle after that edge. A write completes and `req_ready` returns after 11 cycles; for a read, `req_ready` returns after 16. The scoreboard records, for each read, the cycle in which its response must appear. The response monitor then compares both the data and the arrival cycle against that record.

Pin-level intervals are measured by sampling the pins at every falling edge while `req_ready` is low. These intervals are the write pulse, the wait before the driver turns on, the data setup and hold, and the read strobe. The bench's memory model only returns valid data once the read strobe has been low for several cycles. It returns a distinct filler pattern on disabled lanes. A capture that comes too early, or a lane that is not zeroed, therefore shows up as a data mismatch.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  // One-hot phases: each strobe decodes from a single flop.
  typedef enum logic [3:0] {
    PH_IDLE  = 4'b0001,
    PH_SETUP = 4'b0010,
    PH_ACT   = 4'b0100,
    PH_REC   = 4'b1000
  } phase_e;

  // Nanoseconds to cycles, rounded up, floor of one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a - b, clamped at zero.
  function automatic int unsigned sub_sat(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
`timescale 1ns/1ps
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int unsigned CW       = 4,
  parameter int unsigned SU_LEN   = 1,
  parameter int unsigned WA_LEN   = 9,
  parameter int unsigned RA_LEN   = 11,
  parameter int unsigned WREC_LEN = 1,
  parameter int unsigned RREC_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  output phase_e        phase,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          cmd_wr
);

  logic [CW-1:0] len;

  // Length of the current phase, in cycles.
  always_comb begin
    unique case (phase)
      PH_SETUP: len = CW'(SU_LEN);
      PH_ACT:   len = cmd_wr ? CW'(WA_LEN) : CW'(RA_LEN);
      PH_REC:   len = cmd_wr ? CW'(WREC_LEN) : CW'(RREC_LEN);
      default:  len = CW'(1);
    endcase
  end

  assign last = (cnt == len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      cmd_wr <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (start) begin
            phase  <= PH_SETUP;
            cmd_wr <= start_wr;
          end
        end
        PH_SETUP, PH_ACT, PH_REC: begin
          if (last) begin
            cnt <= '0;
            unique case (phase)
              PH_SETUP: phase <= PH_ACT;
              PH_ACT:   phase <= PH_REC;
              default:  phase <= PH_IDLE;
            endcase
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/sram_lane_pins.sv
`timescale 1ns/1ps
module sram_lane_pins
  import sram_lane_pkg::*;
#(
  parameter int unsigned AW    = 19,
  parameter int unsigned LANES = 2,
  parameter int unsigned CW    = 4,
  parameter int unsigned TURN  = 4,
  localparam int unsigned DW   = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_mask,
  input  phase_e           phase,
  input  logic [CW-1:0]    cnt,
  input  logic             cmd_wr,
  output logic [LANES-1:0] cmd_mask,
  output logic [AW-1:0]    ram_addr,
  output logic             ram_sel_n,
  output logic             ram_sel,
  output logic             ram_wr_n,
  output logic             ram_rd_n,
  output logic [LANES-1:0] ram_be_n,
  output logic [DW-1:0]    ram_dq_o,
  output logic             ram_dq_oe
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          busy;

  // Request fields are latched on acceptance and held until idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      cmd_mask <= '0;
    end else if (start) begin
      addr_q   <= req_addr;
      wdata_q  <= req_wdata;
      cmd_mask <= req_mask;
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign ram_addr  = addr_q;
  assign ram_sel_n = !busy;
  assign ram_sel   = busy;
  assign ram_wr_n  = !((phase == PH_ACT) && cmd_wr);
  assign ram_rd_n  = !((phase == PH_ACT) && !cmd_wr);
  assign ram_dq_o  = wdata_q;

  // Driver on after the bus-release wait inside the write pulse; held through hold.
  assign ram_dq_oe = cmd_wr && (((phase == PH_ACT) && (cnt >= CW'(TURN))) || (phase == PH_REC));

  for (genvar i = 0; i < LANES; i++) begin : g_be
    assign ram_be_n[i] = !(busy && cmd_mask[i]);
  end

endmodule

// File: rtl/sram_lane_rdcap.sv
`timescale 1ns/1ps
module sram_lane_rdcap #(
  parameter int unsigned LANES = 2,
  localparam int unsigned DW   = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [LANES-1:0] mask,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata,
  output logic             rsp_valid
);

  logic [DW-1:0] lane_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_d[i*8 +: 8] = mask[i] ? dq_i[i*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= capture;
      if (capture) rdata <= lane_d;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned AW        = 19,
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned T_AS_NS   = 0,
  parameter int unsigned T_WP_NS   = 45,
  parameter int unsigned T_DS_NS   = 25,
  parameter int unsigned T_WH_NS   = 0,
  parameter int unsigned T_WC_NS   = 55,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_OA_NS   = 25,
  parameter int unsigned T_RC_NS   = 55,
  parameter int unsigned T_OFF_NS  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_sel_n,
  output logic          ram_sel,
  output logic          ram_wr_n,
  output logic          ram_rd_n,
  output logic          ram_hi_n,
  output logic          ram_lo_n,
  input  logic [15:0]   ram_dq_i,
  output logic [15:0]   ram_dq_o,
  output logic          ram_dq_oe
);

  localparam int unsigned LANES    = 2;
  localparam int unsigned SU_LEN   = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int unsigned TURN     = ns_to_cyc(T_OFF_NS, CLK_NS);
  localparam int unsigned WA_LEN   = max_u(ns_to_cyc(T_WP_NS, CLK_NS), TURN + ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int unsigned WREC_LEN = max_u(ns_to_cyc(T_WH_NS, CLK_NS),
                                           sub_sat(ns_to_cyc(T_WC_NS, CLK_NS), SU_LEN + WA_LEN));
  localparam int unsigned RA_LEN   = max_u(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OA_NS, CLK_NS));
  localparam int unsigned RREC_LEN = max_u(TURN, sub_sat(ns_to_cyc(T_RC_NS, CLK_NS), SU_LEN + RA_LEN));
  localparam int unsigned MAX_LEN  = max_u(max_u(SU_LEN, WA_LEN), max_u(max_u(RA_LEN, WREC_LEN), RREC_LEN));
  localparam int unsigned CW       = $clog2(MAX_LEN + 1);

  phase_e           phase;
  logic [CW-1:0]    cnt;
  logic             last;
  logic             cmd_wr;
  logic             start;
  logic [LANES-1:0] cmd_mask;
  logic [LANES-1:0] be_n;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign ram_lo_n  = be_n[0];
  assign ram_hi_n  = be_n[1];

  sram_lane_seq #(
    .CW(CW), .SU_LEN(SU_LEN), .WA_LEN(WA_LEN), .RA_LEN(RA_LEN),
    .WREC_LEN(WREC_LEN), .RREC_LEN(RREC_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(req_write),
    .phase(phase), .cnt(cnt), .last(last), .cmd_wr(cmd_wr)
  );

  sram_lane_pins #(
    .AW(AW), .LANES(LANES), .CW(CW), .TURN(TURN)
  ) u_pins (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .phase(phase), .cnt(cnt), .cmd_wr(cmd_wr), .cmd_mask(cmd_mask),
    .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
    .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n), .ram_be_n(be_n),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe)
  );

  sram_lane_rdcap #(
    .LANES(LANES)
  ) u_rdcap (
    .clk(clk), .rst_n(rst_n),
    .capture((phase == PH_ACT) && !cmd_wr && last),
    .mask(cmd_mask), .dq_i(ram_dq_i),
    .rdata(rsp_rdata), .rsp_valid(rsp_valid)
  );

endmodule

// File: rtl/sram_lane_chk.sv
`timescale 1ns/1ps
module sram_lane_chk #(
  parameter int unsigned AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] ram_addr,
  input logic          ram_sel_n,
  input logic          ram_sel,
  input logic          ram_wr_n,
  input logic          ram_rd_n,
  input logic          ram_dq_oe
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_wr_n && ram_rd_n && !ram_dq_oe && ram_sel_n && !ram_sel));

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(ram_addr));

  assert_drive_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (!ram_sel_n && ram_sel));

  assert_late_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_wr_n) |-> !ram_dq_oe);

  assert_no_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_dq_oe || !ram_wr_n) |-> ram_rd_n);

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind sram_lane_ctrl sram_lane_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel(ram_sel),
  .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n), .ram_dq_oe(ram_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [18:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] ram_addr;
  logic        ram_sel_n, ram_sel, ram_wr_n, ram_rd_n, ram_hi_n, ram_lo_n;
  logic [15:0] ram_dq_i, ram_dq_o;
  logic        ram_dq_oe;

  always #2.5 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n),
    .ram_hi_n(ram_hi_n), .ram_lo_n(ram_lo_n), .ram_dq_i(ram_dq_i), .ram_dq_o(ram_dq_o),
    .ram_dq_oe(ram_dq_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int clash = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [0:255];
  logic [15:0] shadow [0:255];
  logic        rd_cond;
  int          rd_age = 0;
  int          drv_run = 0;
  logic        wr_n_prev = 1'b1;
  logic [7:0]  idx;

  assign idx     = ram_addr[7:0];
  assign rd_cond = !ram_sel_n && ram_sel && ram_wr_n && !ram_rd_n;
  // Valid data only after the read strobe has been low for a while; filler on disabled lanes.
  assign ram_dq_i = (rd_cond && rd_age >= 6) ?
                    {ram_hi_n ? 8'hA5 : mem[idx][15:8], ram_lo_n ? 8'h5A : mem[idx][7:0]} :
                    16'hDEAD;

  always @(posedge clk) rd_age <= rd_cond ? rd_age + 1 : 0;

  always @(negedge clk) begin
    if (rd_cond && ram_dq_oe) clash++;
    if (!ram_sel_n && ram_sel && !ram_wr_n && ram_dq_oe) begin
      if (!ram_lo_n) mem[idx][7:0]  = ram_dq_o[7:0];
      if (!ram_hi_n) mem[idx][15:8] = ram_dq_o[15:8];
    end
    if (!ram_wr_n && ram_dq_oe) drv_run++;
    if (!wr_n_prev && ram_wr_n) begin
      check(drv_run >= 5, "R8 data setup before write end", drv_run, 5);
      drv_run = 0;
    end
    wr_n_prev = ram_wr_n;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] d;
    int          due;
    string       tag;
  } exp_t;
  exp_t q[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R11 response without request", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rsp_rdata == e.d, e.tag, rsp_rdata, e.d);
        check(cyc == e.due, "R10 response cycle", cyc, e.due);
      end
    end
  end

  task automatic do_req(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] m, input string tag);
    int acc, busy, wrlow, rdlow, first_drv, drv_in_wr, drv_after, drv_any;
    int nosel, bad_addr, bad_be;
    logic [7:0] i;
    i = a[7:0];
    busy = 0; wrlow = 0; rdlow = 0; first_drv = -1; drv_in_wr = 0; drv_after = 0;
    drv_any = 0; nosel = 0; bad_addr = 0; bad_be = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
    if (wr) begin
      if (m[0]) shadow[i][7:0]  = d[7:0];
      if (m[1]) shadow[i][15:8] = d[15:8];
    end else begin
      exp_t e;
      e.d   = {m[1] ? shadow[i][15:8] : 8'h00, m[0] ? shadow[i][7:0] : 8'h00};
      e.due = acc + 12;
      e.tag = tag;
      q.push_back(e);
    end
    while (!req_ready && busy < 100) begin
      busy++;
      if (!ram_wr_n) wrlow++;
      if (!ram_rd_n) rdlow++;
      if (ram_dq_oe) drv_any++;
      if (ram_dq_oe && first_drv < 0) first_drv = ram_wr_n ? wrlow : wrlow - 1;
      if (ram_dq_oe && !ram_wr_n) drv_in_wr++;
      if (ram_dq_oe && ram_wr_n) drv_after++;
      if (ram_sel_n || !ram_sel) nosel++;
      if (ram_addr != a) bad_addr++;
      if (ram_lo_n != !m[0] || ram_hi_n != !m[1]) bad_be++;
      @(negedge clk);
    end
    check(!ram_dq_oe && ram_sel_n && !ram_sel, "R1 idle pins after access", ram_dq_oe, 0);
    check(nosel == 0, "R2 selected throughout access", nosel, 0);
    check(bad_addr == 0, "R2 address held", bad_addr, 0);
    check(bad_be == 0, "R4 lane enables follow mask", bad_be, 0);
    if (wr) begin
      check(busy == 11, "R7 write occupancy", busy, 11);
      check(wrlow == 9, "R7 write pulse width", wrlow, 9);
      check(rdlow == 0, "R9 read strobe off during write", rdlow, 0);
      if (m != 2'b00) begin
        check(first_drv == 4, "R8 driver waits for bus release", first_drv, 4);
        check(drv_in_wr == 5, "R8 driven cycles inside pulse", drv_in_wr, 5);
        check(drv_after == 1, "R8 hold cycle", drv_after, 1);
      end
    end else begin
      check(busy == 16, "R10 read occupancy", busy, 16);
      check(rdlow == 11, "R10 read strobe width", rdlow, 11);
      check(drv_any == 0, "R9 no drive during read", drv_any, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) begin
      mem[k] = 16'h0000;
      shadow[k] = 16'h0000;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = 2'b00;
    repeat (3) @(negedge clk);
    check(req_ready && ram_sel_n && !ram_sel && ram_wr_n && ram_rd_n && !ram_dq_oe && !rsp_valid,
          "R1 reset state", {req_ready, ram_sel_n, ram_sel, ram_wr_n, ram_rd_n, ram_dq_oe, rsp_valid},
          7'b1101100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: no request while valid is low
    req_write = 1'b1; req_addr = 19'h00003; req_wdata = 16'h5555; req_mask = 2'b11;
    begin
      int act = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!ram_sel_n || ram_sel || !ram_wr_n || !req_ready) act++;
      end
      check(act == 0, "R11 pins idle with valid low", act, 0);
    end

    do_req(1'b1, 19'h00000, 16'h1234, 2'b11, "R3");
    do_req(1'b0, 19'h00000, 16'h0000, 2'b11, "R3 full word read");
    do_req(1'b1, 19'h00001, 16'hBEEF, 2'b11, "R3");
    do_req(1'b1, 19'h00001, 16'h00CC, 2'b01, "R4");
    do_req(1'b0, 19'h00001, 16'h0000, 2'b11, "R4 low lane write");
    do_req(1'b1, 19'h00001, 16'h7700, 2'b10, "R4");
    do_req(1'b0, 19'h00001, 16'h0000, 2'b11, "R4 high lane write");
    do_req(1'b0, 19'h00001, 16'h0000, 2'b01, "R5 low lane read, high zero");
    do_req(1'b0, 19'h00001, 16'h0000, 2'b10, "R5 high lane read, low zero");
    do_req(1'b1, 19'h00002, 16'hFFFF, 2'b00, "R6");
    do_req(1'b0, 19'h00002, 16'h0000, 2'b11, "R6 empty-mask write ignored");
    do_req(1'b1, 19'h00000, 16'hAAAA, 2'b00, "R6");
    do_req(1'b0, 19'h00000, 16'h0000, 2'b11, "R6 earlier data intact");
    do_req(1'b0, 19'h00000, 16'h0000, 2'b00, "R6 empty-mask read zero");
    do_req(1'b1, 19'h7FF80, 16'hC3A5, 2'b11, "R3");
    do_req(1'b0, 19'h7FF80, 16'h0000, 2'b11, "R3 high address");

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R10 every read answered", q.size(), 0);
    check(clash == 0, "R9 bus collision cycles", clash, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule